// File: doc/BRIEF.md
# Bus Cycle Acknowledge Generator

This block is synchronous glue logic for a 16-bit processor whose bus is asynchronous, where the memories and peripherals on the bus cannot acknowledge a transfer themselves. A small saturating counter runs on the system clock, which is nominally 8 MHz. The counter is held at zero while both data strobes are negated. It counts while either strobe is asserted. One stage of the counter acts as a tap, and the tap drives the active-low data-acknowledge output. Every read or write cycle therefore gets the same fixed number of wait states. With the default tap on the second stage, that is one wait state, which gives attached devices an access window of 250 ns.

One slow device, a dot-matrix display, needs the processor's slower synchronous peripheral cycle of about 1 µs. While the display select is asserted, the block never asserts data-acknowledge. It drives the active-low valid-peripheral-address output instead, for as long as the display select and the address strobe are both asserted. Both outputs are registered. Reset is synchronous and active high.

Top module: `bus_ack_gen`

## Requirements
- R1: In the clock cycle after a rising edge that samples `rst` high, `dtack_n` and `vpa_n` are both 1.
- R2: `disp_cs_n` must be 1 at each edge counted. Counting from the first rising edge that samples at least one data strobe low, `dtack_n` goes to 0 at edge number 2^ACK_TAP + 1, which is edge 3 with the default ACK_TAP = 1. It is 1 at every earlier edge.
- R3: The latency in R2 is the same whether the strobe held low is `uds_n` alone, `lds_n` alone, or both.
- R4: While a strobe stays low and `disp_cs_n` stays 1, `dtack_n` stays 0 however long the cycle lasts. The counter saturates and does not wrap.
- R5: After a rising edge that samples both `uds_n` and `lds_n` high, `dtack_n` is 1. The next strobe assertion again waits the full latency of R2.
- R6: After a rising edge that samples `disp_cs_n` low, `dtack_n` is 1, whatever the counter holds.
- R7: After a rising edge that samples both `disp_cs_n` and `as_n` low, `vpa_n` is 0. After an edge that samples either of them high, `vpa_n` is 1.
- R8: `dtack_n` and `vpa_n` are never 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominally 8 MHz |
| rst | input | 1 | Synchronous reset, active high |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| as_n | input | 1 | Address strobe, active low |
| disp_cs_n | input | 1 | Display chip select, active low |
| dtack_n | output | 1 | Data acknowledge, active low, registered |
| vpa_n | output | 1 | Valid peripheral address, active low, registered |

## Verification
The assertions assume that the strobes and the display select are already synchronous to `clk`, so each one is a stable level at every rising edge. They also assume that any display select which matters for a cycle is held from the first strobe edge onward. A select asserted partway through a cycle is only checked for suppressing acknowledge from the next edge on.

The stimulus changes every input one nanosecond after a rising edge, and it returns all strobes to idle between accesses. The sweep covers:
- each of the three strobe patterns;
- display select on and off;
- hold lengths from one clock up to past saturation.

A few directed cases are added on top of the sweep:
- a select that arrives mid-cycle;
- an address strobe held without any data strobe;
- a reset in the middle of an access.

// File: rtl/bag_pkg.sv
package bag_pkg;

  // Kind of bus cycle, as decoded from the strobes and the display select
  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_MEM    = 2'd1,
    CYC_PERIPH = 2'd2
  } cyc_kind_e;

  // Number of counter stages needed for a given tap position
  function automatic int tap_width(input int tap);
    return tap + 1;
  endfunction

endpackage

// File: rtl/bag_cycle_class.sv
module bag_cycle_class
  import bag_pkg::*;
(
  input  logic      uds_n,
  input  logic      lds_n,
  input  logic      as_n,
  input  logic      disp_cs_n,
  output logic      strobe_act,
  output logic      periph_hold,
  output cyc_kind_e kind
);

  always_comb begin
    strobe_act  = ~uds_n | ~lds_n;
    periph_hold = ~disp_cs_n & ~as_n;
    if (~disp_cs_n)
      kind = CYC_PERIPH;
    else if (strobe_act)
      kind = CYC_MEM;
    else
      kind = CYC_IDLE;
  end

endmodule

// File: rtl/bag_strobe_ctr.sv
module bag_strobe_ctr #(
  parameter int ACK_TAP = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_act,
  output logic tap_hit
);
  import bag_pkg::*;

  localparam int CNT_W = tap_width(ACK_TAP);
  localparam logic [CNT_W-1:0] TAP_VAL = CNT_W'(1) << ACK_TAP;

  logic [CNT_W-1:0] cnt_q;

  generate
    if (ACK_TAP == 0) begin : g_single
      // One stage: acknowledge after the first strobe edge
      always_ff @(posedge clk) begin
        if (rst || !strobe_act) cnt_q <= '0;
        else                    cnt_q <= 1'b1;
      end
    end else begin : g_multi
      // Saturate once the tap stage is set, so the tap never drops
      always_ff @(posedge clk) begin
        if (rst || !strobe_act)  cnt_q <= '0;
        else if (!cnt_q[ACK_TAP]) cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  assign tap_hit = cnt_q[ACK_TAP];

  logic unused_tap_val;
  assign unused_tap_val = ^TAP_VAL;

endmodule

// File: rtl/bag_ack_regs.sv
module bag_ack_regs
  import bag_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cyc_kind_e kind,
  input  logic      tap_hit,
  input  logic      periph_hold,
  output logic      dtack_n,
  output logic      vpa_n
);

  logic dtack_d, vpa_d;

  always_comb begin
    dtack_d = 1'b1;
    vpa_d   = 1'b1;
    unique case (kind)
      CYC_MEM:    dtack_d = ~tap_hit;
      CYC_PERIPH: vpa_d   = ~periph_hold;
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dtack_n <= 1'b1;
      vpa_n   <= 1'b1;
    end else begin
      dtack_n <= dtack_d;
      vpa_n   <= vpa_d;
    end
  end

endmodule

// File: rtl/bus_ack_gen.sv
module bus_ack_gen #(
  parameter int ACK_TAP = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic uds_n,
  input  logic lds_n,
  input  logic as_n,
  input  logic disp_cs_n,
  output logic dtack_n,
  output logic vpa_n
);
  import bag_pkg::*;

  logic      strobe_act;
  logic      periph_hold;
  logic      tap_hit;
  cyc_kind_e kind;

  bag_cycle_class u_class (
    .uds_n       (uds_n),
    .lds_n       (lds_n),
    .as_n        (as_n),
    .disp_cs_n   (disp_cs_n),
    .strobe_act  (strobe_act),
    .periph_hold (periph_hold),
    .kind        (kind)
  );

  bag_strobe_ctr #(.ACK_TAP(ACK_TAP)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .strobe_act (strobe_act),
    .tap_hit    (tap_hit)
  );

  bag_ack_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .kind        (kind),
    .tap_hit     (tap_hit),
    .periph_hold (periph_hold),
    .dtack_n     (dtack_n),
    .vpa_n       (vpa_n)
  );

endmodule

// File: rtl/bag_checks.sv
module bag_checks #(
  parameter int ACK_TAP = 1
) (
  input logic clk,
  input logic rst,
  input logic uds_n,
  input logic lds_n,
  input logic as_n,
  input logic disp_cs_n,
  input logic dtack_n,
  input logic vpa_n
);

  localparam int TAP_VAL = 1 << ACK_TAP;
  localparam int RUN_MAX = TAP_VAL + 2;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic strb;
  assign strb = ~uds_n | ~lds_n;

  // Number of consecutive edges that sampled a strobe, saturating at RUN_MAX
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !strb)                run_q <= '0;
    else if (run_q != RUN_W'(RUN_MAX)) run_q <= run_q + 1'b1;
  end

  // R2: acknowledge never falls before the full strobe count is reached
  a_r2_not_early: assert property (@(posedge clk) disable iff (rst)
    $fell(dtack_n) |-> (run_q >= RUN_W'(TAP_VAL + 1)));

  // R2: acknowledge follows the edge that completes the count
  a_r2_on_time: assert property (@(posedge clk) disable iff (rst)
    (run_q == RUN_W'(TAP_VAL) && strb && disp_cs_n) |=> !dtack_n);

  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (uds_n && lds_n) |=> dtack_n);

  a_r6_display_inhibit: assert property (@(posedge clk) disable iff (rst)
    !disp_cs_n |=> dtack_n);

  a_r7_vpa_on: assert property (@(posedge clk) disable iff (rst)
    (!disp_cs_n && !as_n) |=> !vpa_n);

  a_r7_vpa_off: assert property (@(posedge clk) disable iff (rst)
    (disp_cs_n || as_n) |=> vpa_n);

  a_r8_one_ack: assert property (@(posedge clk) disable iff (rst)
    (dtack_n || vpa_n));

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (dtack_n && vpa_n));

endmodule

bind bus_ack_gen bag_checks #(.ACK_TAP(ACK_TAP)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .uds_n     (uds_n),
  .lds_n     (lds_n),
  .as_n      (as_n),
  .disp_cs_n (disp_cs_n),
  .dtack_n   (dtack_n),
  .vpa_n     (vpa_n)
);

// File: tb/test_bus_ack_gen.sv
`timescale 1ns/1ps
module test_bus_ack_gen;

  localparam int ACK_TAP = 1;
  localparam int LAT     = (1 << ACK_TAP) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uds_n = 1'b1, lds_n = 1'b1, as_n = 1'b1, disp_cs_n = 1'b1;
  logic dtack_n, vpa_n;
  int   nvec = 0, nfail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  bus_ack_gen #(.ACK_TAP(ACK_TAP)) i_bus_ack_gen (
    .clk(clk), .rst(rst), .uds_n(uds_n), .lds_n(lds_n),
    .as_n(as_n), .disp_cs_n(disp_cs_n), .dtack_n(dtack_n), .vpa_n(vpa_n)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic got_d, input logic exp_d,
                     input logic got_v, input logic exp_v);
    nvec++;
    if (got_d !== exp_d || got_v !== exp_v) begin
      nfail++;
      $display("FAIL %s: dtack_n=%b vpa_n=%b expected dtack_n=%b vpa_n=%b",
               req, got_d, got_v, exp_d, exp_v);
    end
  endtask

  task automatic idle();
    uds_n = 1'b1; lds_n = 1'b1; as_n = 1'b1; disp_cs_n = 1'b1;
  endtask

  // ds: bit1 = upper strobe low, bit0 = lower strobe low
  task automatic access(input logic [1:0] ds, input bit disp, input int hold);
    uds_n = ~ds[1]; lds_n = ~ds[0]; as_n = 1'b0; disp_cs_n = ~disp;
    for (int j = 1; j <= hold; j++) begin
      step();
      // R2 R3 R4 R6 R7 R8: expected levels after edge j
      chk(disp ? "R6/R7" : "R2/R3/R4",
          dtack_n, (!disp && j >= LAT) ? 1'b0 : 1'b1,
          vpa_n, disp ? 1'b0 : 1'b1);
    end
    idle();
    step();
    chk("R5", dtack_n, 1'b1, vpa_n, 1'b1);
  endtask

  initial begin
    idle();
    rst = 1'b1;
    step(); step();
    chk("R1", dtack_n, 1'b1, vpa_n, 1'b1);
    rst = 1'b0;
    step();
    chk("R1", dtack_n, 1'b1, vpa_n, 1'b1);

    // Sweep: strobe pattern x display select x hold length
    for (int d = 0; d < 2; d++)
      for (int p = 1; p < 4; p++)
        for (int h = 1; h <= 8; h++)
          access(2'(p), bit'(d), h);

    // R4: long hold, no wrap
    access(2'b11, 1'b0, 40);

    // R6: display selected mid-cycle drops acknowledge at the next edge
    uds_n = 1'b0; as_n = 1'b0;
    for (int j = 1; j <= LAT; j++) step();
    chk("R2", dtack_n, 1'b0, vpa_n, 1'b1);
    disp_cs_n = 1'b0;
    step();
    chk("R6", dtack_n, 1'b1, vpa_n, 1'b0);
    idle(); step();
    chk("R5", dtack_n, 1'b1, vpa_n, 1'b1);

    // R7: address strobe with display select, no data strobe
    as_n = 1'b0; disp_cs_n = 1'b0;
    step();
    chk("R7", dtack_n, 1'b1, vpa_n, 1'b0);
    as_n = 1'b1;
    step();
    chk("R7", dtack_n, 1'b1, vpa_n, 1'b1);
    idle(); step();

    // R1: reset in the middle of an acknowledged access
    lds_n = 1'b0; as_n = 1'b0;
    for (int j = 1; j <= LAT + 1; j++) step();
    chk("R4", dtack_n, 1'b0, vpa_n, 1'b1);
    rst = 1'b1;
    step();
    chk("R1", dtack_n, 1'b1, vpa_n, 1'b1);
    rst = 1'b0;
    // R5: counter restarts after reset with the strobe still low
    for (int j = 1; j <= LAT; j++) begin
      step();
      chk("R5", dtack_n, (j >= LAT) ? 1'b0 : 1'b1, vpa_n, 1'b1);
    end
    idle(); step();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule